// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block sits in front of a vector execution unit and decides, before any element is processed, whether a vector arithmetic or compare instruction has to trap as illegal. It receives the decoded register fields of the instruction, a few decoded flags, and the current vector state: whether the unit is enabled, whether the active type setting is invalid, and the register group size. From these it produces a single illegal flag and a cause code that records which rule fired first.

The checker is purely combinational and executes nothing. Registers are grouped by a power-of-two group multiplier, and each vector operand group has to start on a multiple of its size. A compare writes its result as a mask, so its destination is always one register and is never aligned to the group size. Under grouping that destination must not land inside any source group. A masked arithmetic instruction may not write register 0, because that register holds the mask it reads.

Top module: `vlegal_check`

## Requirements
- R1: When `vec_en` is 0 the result is illegal with cause 1 (disabled), whatever every other input holds.
- R2: When enabled and `vtype_bad` is 1 the result is illegal with cause 2 (invalid type).
- R3: With group size G = 2^`grp_log2` greater than 1, the instruction is illegal with cause 3 (misaligned) when `vs2`, or `vs1` while `vs1_vec` is 1, or the destination of a non-compare, is not a multiple of G. When `vs1_vec` is 0, the `vs1` field plays no part in any rule.
- R4: The destination of a compare (`is_cmp`=1) is a single mask register and is never checked for alignment.
- R5: A masked (`vm`=0) non-compare with destination 0 is illegal with cause 4. An unmasked one, or a masked compare, writing register 0 is legal.
- R6: With G greater than 1, a compare whose destination lies inside the `vs2` group, or inside the `vs1` group while `vs1_vec` is 1, is illegal with cause 5 (overlap).
- R7: With G equal to 1, a compare may write a register that is also one of its sources.
- R8: A compare whose destination lies outside every source group is legal.
- R9: When several rules fire, the cause is the first in the order disabled, invalid type, misaligned, register-0 rule, overlap.
- R10: `illegal` is 1 exactly when `cause` is non-zero. A legal instruction reports cause 0.
- R11: `grp_log2` values 0, 1, 2 and 3 select group sizes 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_en | input | 1 | Vector instructions enabled |
| vtype_bad | input | 1 | Current type setting is invalid |
| grp_log2 | input | 2 | Base-2 log of register group size |
| vd | input | 5 | Destination register number |
| vs1 | input | 5 | First source field (register or scalar selector) |
| vs2 | input | 5 | Second source register number |
| vs1_vec | input | 1 | The vs1 field names a vector register group |
| vm | input | 1 | 1 = unmasked, 0 = masked by register 0 |
| is_cmp | input | 1 | Instruction writes a mask result |
| illegal | output | 1 | Instruction must trap |
| cause | output | 3 | 0 none, 1 disabled, 2 invalid type, 3 misaligned, 4 register-0 rule, 5 overlap |

## Verification
A vector table tries each rule on its own, and then in pairs that fire together, so the cause code shows whether the priority order is respected. Compare rows with odd destinations separate the overlap rule from the alignment rule, because the same field values must give cause 5 and not cause 3. Rows in which `vs1` holds a misaligned or overlapping number while `vs1_vec` is 0 show that a scalar operand is kept out of both checks. A sweep over every destination number at group size 2 checks the alignment boundary register by register.

// File: rtl/vlegal_check.sv
module vlegal_check #(
  parameter int NREG  = 32,
  parameter int GRP_W = 2
) (
  input  logic                     vec_en,
  input  logic                     vtype_bad,
  input  logic [GRP_W-1:0]         grp_log2,
  input  logic [$clog2(NREG)-1:0]  vd,
  input  logic [$clog2(NREG)-1:0]  vs1,
  input  logic [$clog2(NREG)-1:0]  vs2,
  input  logic                     vs1_vec,
  input  logic                     vm,
  input  logic                     is_cmp,
  output logic                     illegal,
  output logic [2:0]               cause
);
  localparam int RW = $clog2(NREG);
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_OFF   = 3'd1;
  localparam logic [2:0] C_VTYPE = 3'd2;
  localparam logic [2:0] C_ALIGN = 3'd3;
  localparam logic [2:0] C_V0    = 3'd4;
  localparam logic [2:0] C_OVL   = 3'd5;

  logic [RW-1:0] lo_mask;
  logic          grouped;
  logic          mis_vd, mis_vs1, mis_vs2;
  logic          in_vs1, in_vs2;
  logic          f_align, f_v0, f_ovl;

  assign lo_mask = RW'((1 << grp_log2) - 1);
  assign grouped = (grp_log2 != '0);

  assign mis_vd  = |(vd  & lo_mask);
  assign mis_vs1 = |(vs1 & lo_mask);
  assign mis_vs2 = |(vs2 & lo_mask);

  assign in_vs2 = ((vd & ~lo_mask) == (vs2 & ~lo_mask));
  assign in_vs1 = ((vd & ~lo_mask) == (vs1 & ~lo_mask));

  assign f_align = grouped & ((!is_cmp & mis_vd) | mis_vs2 | (vs1_vec & mis_vs1));
  assign f_v0    = !is_cmp & !vm & (vd == '0);
  assign f_ovl   = is_cmp & grouped & (in_vs2 | (vs1_vec & in_vs1));

  always_comb begin
    if (!vec_en)        cause = C_OFF;
    else if (vtype_bad) cause = C_VTYPE;
    else if (f_align)   cause = C_ALIGN;
    else if (f_v0)      cause = C_V0;
    else if (f_ovl)     cause = C_OVL;
    else                cause = C_NONE;
  end

  assign illegal = !vec_en | vtype_bad | f_align | f_v0 | f_ovl;

  always_comb begin
    if (!vec_en) begin
      assert_disabled_R1: assert (illegal && cause == C_OFF);
    end
    if (vec_en && vtype_bad) begin
      assert_vtype_R2: assert (cause == C_VTYPE);
    end
    if (vec_en && !vtype_bad && !is_cmp && !vm && vd == '0 && grp_log2 == '0) begin
      assert_v0_masked_R5: assert (cause == C_V0);
    end
    if (is_cmp && vs2 == '0 && (!vs1_vec || vs1 == '0)) begin
      assert_cmp_vd_free_R4: assert (cause != C_ALIGN);
    end
    if (grp_log2 == '0) begin
      assert_no_overlap_g1_R7: assert (cause != C_OVL && cause != C_ALIGN);
    end
    assert_flag_matches_R10: assert (illegal == (cause != C_NONE));
  end
endmodule

// File: tb/sim_vlegal_check.sv
module sim_vlegal_check;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       vec_en, vtype_bad, vs1_vec, vm, is_cmp;
  logic [1:0] grp_log2;
  logic [4:0] vd, vs1, vs2;
  logic       illegal;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;

  vlegal_check u0 (
    .vec_en(vec_en), .vtype_bad(vtype_bad), .grp_log2(grp_log2),
    .vd(vd), .vs1(vs1), .vs2(vs2), .vs1_vec(vs1_vec), .vm(vm),
    .is_cmp(is_cmp), .illegal(illegal), .cause(cause)
  );

  // fields: en, vtype_bad, grp, vd, vs1, vs2, vs1_vec, vm, cmp, expected cause, req
  localparam int N = 26;
  localparam logic [28:0] TBL [N] = '{
    {1'b0,1'b0,2'd0,5'd4, 5'd1, 5'd2, 1'b1,1'b1,1'b0,3'd0+3'd1,4'd1},  // R1
    {1'b0,1'b1,2'd1,5'd3, 5'd3, 5'd3, 1'b1,1'b0,1'b1,3'd1,4'd9},       // R9 disabled wins
    {1'b1,1'b1,2'd0,5'd4, 5'd1, 5'd2, 1'b1,1'b1,1'b0,3'd2,4'd2},       // R2
    {1'b1,1'b1,2'd1,5'd3, 5'd1, 5'd2, 1'b1,1'b0,1'b0,3'd2,4'd9},       // R9 vtype over align
    {1'b1,1'b0,2'd1,5'd3, 5'd4, 5'd2, 1'b1,1'b1,1'b0,3'd3,4'd3},       // R3 odd vd
    {1'b1,1'b0,2'd1,5'd4, 5'd6, 5'd3, 1'b1,1'b1,1'b0,3'd3,4'd3},       // R3 odd vs2
    {1'b1,1'b0,2'd1,5'd4, 5'd5, 5'd2, 1'b1,1'b1,1'b0,3'd3,4'd3},       // R3 odd vector vs1
    {1'b1,1'b0,2'd1,5'd4, 5'd5, 5'd2, 1'b0,1'b1,1'b0,3'd0,4'd3},       // R3 scalar vs1 ignored
    {1'b1,1'b0,2'd3,5'd8, 5'd16,5'd12,1'b1,1'b1,1'b0,3'd3,4'd11},      // R11 group 8
    {1'b1,1'b0,2'd3,5'd8, 5'd16,5'd24,1'b1,1'b1,1'b0,3'd0,4'd11},      // R11 group 8 ok
    {1'b1,1'b0,2'd2,5'd4, 5'd8, 5'd12,1'b1,1'b1,1'b0,3'd0,4'd11},      // R11 group 4 ok
    {1'b1,1'b0,2'd2,5'd6, 5'd8, 5'd12,1'b1,1'b1,1'b0,3'd3,4'd11},      // R11 group 4 vd=6
    {1'b1,1'b0,2'd0,5'd0, 5'd1, 5'd2, 1'b1,1'b0,1'b0,3'd4,4'd5},       // R5 masked arith v0
    {1'b1,1'b0,2'd0,5'd0, 5'd1, 5'd2, 1'b1,1'b1,1'b0,3'd0,4'd5},       // R5 unmasked
    {1'b1,1'b0,2'd0,5'd0, 5'd1, 5'd2, 1'b1,1'b0,1'b1,3'd0,4'd5},       // R5 masked compare
    {1'b1,1'b0,2'd1,5'd0, 5'd1, 5'd2, 1'b1,1'b0,1'b0,3'd3,4'd9},       // R9 align over v0
    {1'b1,1'b0,2'd1,5'd3, 5'd6, 5'd2, 1'b1,1'b1,1'b1,3'd5,4'd4},       // R4 odd cmp vd -> overlap
    {1'b1,1'b0,2'd1,5'd2, 5'd6, 5'd2, 1'b1,1'b1,1'b1,3'd5,4'd6},       // R6 vs2 group
    {1'b1,1'b0,2'd1,5'd7, 5'd6, 5'd2, 1'b1,1'b1,1'b1,3'd5,4'd6},       // R6 vs1 group
    {1'b1,1'b0,2'd1,5'd2, 5'd0, 5'd2, 1'b0,1'b1,1'b1,3'd5,4'd6},       // R6 scalar form
    {1'b1,1'b0,2'd1,5'd7, 5'd6, 5'd2, 1'b0,1'b1,1'b1,3'd0,4'd6},       // R6 scalar vs1 ignored
    {1'b1,1'b0,2'd0,5'd2, 5'd0, 5'd2, 1'b0,1'b1,1'b1,3'd0,4'd7},       // R7
    {1'b1,1'b0,2'd1,5'd8, 5'd6, 5'd2, 1'b1,1'b1,1'b1,3'd0,4'd8},       // R8
    {1'b1,1'b0,2'd1,5'd5, 5'd6, 5'd2, 1'b1,1'b1,1'b1,3'd0,4'd4},       // R4 odd vd legal
    {1'b1,1'b0,2'd1,5'd2, 5'd6, 5'd3, 1'b1,1'b1,1'b1,3'd3,4'd9},       // R9 align over overlap
    {1'b1,1'b0,2'd3,5'd15,5'd0, 5'd8, 1'b0,1'b0,1'b1,3'd5,4'd6}        // R6 group 8
  };

  task automatic check(input int req, input logic [2:0] exp_c);
    checks++;
    if (cause !== exp_c || illegal !== (exp_c != 3'd0)) begin
      errors++;
      $display("FAIL R%0d: illegal=%0b cause=%0d expected illegal=%0b cause=%0d",
               req, illegal, cause, exp_c != 3'd0, exp_c);
    end
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_en = 0; vtype_bad = 0; grp_log2 = 0; vd = 0; vs1 = 0; vs2 = 0;
    vs1_vec = 0; vm = 0; is_cmp = 0;
    @(negedge clk);
    check(1, 3'd1);  // R1 state with all inputs low

    for (int i = 0; i < N; i++) begin
      @(posedge clk);
      {vec_en, vtype_bad, grp_log2, vd, vs1, vs2, vs1_vec, vm, is_cmp} = TBL[i][28:7];
      @(negedge clk);
      check(int'(TBL[i][3:0]), TBL[i][6:4]);   // R10 checked on every row
    end

    // R3 sweep: group 2 arithmetic, every destination number
    for (int r = 0; r < 32; r++) begin
      @(posedge clk);
      vec_en = 1; vtype_bad = 0; grp_log2 = 2'd1; vd = 5'(r); vs1 = 5'd4; vs2 = 5'd6;
      vs1_vec = 1; vm = 1; is_cmp = 0;
      @(negedge clk);
      check(3, (r % 2 == 1) ? 3'd3 : 3'd0);
    end

    // R1 disabled overrides every other fault at once
    @(posedge clk);
    vec_en = 0; vtype_bad = 1; grp_log2 = 2'd3; vd = 5'd0; vs1 = 5'd1; vs2 = 5'd1;
    vs1_vec = 1; vm = 0; is_cmp = 0;
    @(negedge clk);
    check(1, 3'd1);

    // R7 group 1 compare with vd equal to both vector sources
    @(posedge clk);
    vec_en = 1; vtype_bad = 0; grp_log2 = 2'd0; vd = 5'd9; vs1 = 5'd9; vs2 = 5'd9;
    vs1_vec = 1; vm = 1; is_cmp = 1;
    @(negedge clk);
    check(7, 3'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule